// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small two-plane logic array that turns a handful of input bits into several combinational outputs in sum-of-products form. The first plane holds one AND term per product line. For every input, that line stores a two-bit literal code. The code can leave the input out, use it as it is, use its complement, or force the whole term low. The second plane decides which product lines are ORed onto each output.

The block has two build-time variants. In the programmable variant, a product line may drive any set of outputs, so one term can be shared. In the fixed variant, each output owns a contiguous group of product lines. That group cannot be changed, and only the AND plane is loaded. A function fits only if its minimized cover needs no more terms than the lines available to its output.

Configuration arrives one product line per clock through a write port that carries the line index, the AND-plane codes and the OR-plane selection. The outputs are purely combinational from the inputs and the stored configuration.

Top module: `pla_array`

## Requirements
- R1: After reset, every AND-plane code is 11 and every OR-plane selection bit is 0, so every output reads 0 in both variants.
- R2: The literal code for input i on a product line sits in `cfg_and[2i+1:2i]`. Code 00 leaves the input out, 01 uses the true input, 10 uses its complement, and 11 forces that product term to 0.
- R3: A product line whose codes are all 00 evaluates to 1.
- R4: In the programmable variant, `cfg_or[o]` selects the line being written onto output o. An output is the OR of its selected terms, and an output with no selected line reads 0.
- R5: In the programmable variant, one product line may drive several outputs at the same time.
- R6: The terms A'·B (line 0, code 8'h06) and A·B' (line 1, code 8'h09), both summed onto output 0, make output 0 equal to `din[0] ^ din[1]`.
- R7: In the fixed variant, output o sums exactly lines o·G to o·G+G−1, where G = N_TERM / N_OUT (2 by default), and the `cfg_or` value is ignored.
- R8: A write with `cfg_we` high updates line `cfg_line` at the rising clock edge. With `cfg_we` low, the configuration does not change. Outputs follow `din` in the same cycle, with no register in the path.
- R9: In the fixed variant, lines at index N_OUT·G and above reach no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write enable for one product line |
| cfg_line | input | 3 | Index of the product line to write |
| cfg_and | input | 8 | AND-plane literal codes, two bits per input |
| cfg_or | input | 3 | OR-plane selection of the written line, one bit per output |
| din | input | 4 | Logic inputs |
| dout | output | 3 | Sum-of-products outputs |

## Verification
Both variants are driven from one configuration stream and compared with a behavioural model at every clock. The effect of each literal code is isolated by loading a single-input term and then applying the input at 0 and at 1. All four input combinations are applied to the XOR cover. A term selected onto two outputs, followed by a rewrite that clears its selection, separates the shared programmable sum from the fixed groups, where the same OR data must have no effect. A term at a line outside every fixed group, together with a write attempt made with the enable low, shows which lines and which write strobes actually reach an output.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // Contribution of one literal to its product term
  function automatic logic lit_pass(input logic [1:0] code, input logic bit_in);
    logic r;
    case (lit_code_e'(code))
      LIT_OFF:  r = 1'b1;
      LIT_POS:  r = bit_in;
      LIT_NEG:  r = ~bit_in;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pla_cfg_decode.sv
module pla_cfg_decode #(
  parameter int N_TERM = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_line,
  output logic [N_TERM-1:0] line_wr
);

  for (genvar k = 0; k < N_TERM; k++) begin : g_dec
    always_comb begin
      line_wr[k] = cfg_we && (cfg_line == AW'(k));
    end
  end

  // R8
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_wr));

  // R8
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |-> (line_wr == '0));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_TERM-1:0]   line_wr,
  input  logic [2*N_IN-1:0]   and_data,
  input  logic [N_IN-1:0]     din,
  output logic [N_TERM-1:0]   term
);

  localparam int CW = 2 * N_IN;

  logic [CW-1:0] code_q [N_TERM];
  logic [CW-1:0] code_d [N_TERM];

  function automatic logic any_kill(input logic [CW-1:0] c);
    logic k;
    k = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (c[2*i +: 2] == LIT_KILL) k = 1'b1;
    end
    return k;
  endfunction

  for (genvar k = 0; k < N_TERM; k++) begin : g_line
    // next state
    always_comb begin
      code_d[k] = code_q[k];
      if (line_wr[k]) begin
        code_d[k] = and_data;
      end
    end

    // register, reset state kills the term
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[k] <= '1;
      end else if (line_wr[k]) begin
        code_q[k] <= code_d[k];
      end
    end

    // evaluation
    always_comb begin
      logic acc;
      acc = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        acc = acc & lit_pass(code_q[k][2*i +: 2], din[i]);
      end
      term[k] = acc;
    end

    // R8
    and_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_wr[k] |=> (code_q[k] == $past(and_data)));

    // R8
    and_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_wr[k] |=> $stable(code_q[k]));

    // R3
    empty_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[k] == '0) |-> term[k]);

    // R2
    kill_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_kill(code_q[k]) |-> !term[k]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM   = 8,
  parameter int N_OUT    = 3,
  parameter bit FIXED_OR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TERM-1:0] line_wr,
  input  logic [N_OUT-1:0]  or_data,
  input  logic [N_TERM-1:0] term,
  output logic [N_OUT-1:0]  dout
);

  localparam int GRP = N_TERM / N_OUT;

  if (FIXED_OR) begin : g_fixed
    logic unused_cfg;
    assign unused_cfg = ^{line_wr, or_data, term, clk, rst_n};

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      always_comb begin
        dout[o] = |term[o*GRP +: GRP];
      end

      // R7
      fixed_grp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term[o*GRP +: GRP] == '0) |-> !dout[o]);
    end
  end else begin : g_prog
    logic [N_OUT-1:0]  sel_q [N_TERM];
    logic [N_OUT-1:0]  sel_d [N_TERM];
    logic [N_TERM-1:0] col   [N_OUT];

    for (genvar k = 0; k < N_TERM; k++) begin : g_line
      always_comb begin
        sel_d[k] = sel_q[k];
        if (line_wr[k]) begin
          sel_d[k] = or_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sel_q[k] <= '0;
        end else if (line_wr[k]) begin
          sel_q[k] <= sel_d[k];
        end
      end

      // R8
      or_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr[k] |=> (sel_q[k] == $past(or_data)));
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      always_comb begin
        for (int k = 0; k < N_TERM; k++) begin
          col[o][k] = sel_q[k][o];
        end
      end

      always_comb begin
        dout[o] = |(term & col[o]);
      end

      // R4
      or_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col[o] == '0) |-> !dout[o]);
    end
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN     = 4,
  parameter int N_TERM   = 8,
  parameter int N_OUT    = 3,
  parameter bit FIXED_OR = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(N_TERM)-1:0]   cfg_line,
  input  logic [2*N_IN-1:0]           cfg_and,
  input  logic [N_OUT-1:0]            cfg_or,
  input  logic [N_IN-1:0]             din,
  output logic [N_OUT-1:0]            dout
);

  localparam int AW = $clog2(N_TERM);

  logic              rst_n_int;
  logic [N_TERM-1:0] line_wr;
  logic [N_TERM-1:0] term;

  pla_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pla_cfg_decode #(.N_TERM(N_TERM), .AW(AW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cfg_we   (cfg_we),
    .cfg_line (cfg_line),
    .line_wr  (line_wr)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .line_wr  (line_wr),
    .and_data (cfg_and),
    .din      (din),
    .term     (term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .FIXED_OR(FIXED_OR)) u_or (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .line_wr (line_wr),
    .or_data (cfg_or),
    .term    (term),
    .dout    (dout)
  );

endmodule

// File: tb/pla_array_test.sv
`timescale 1ns/1ps
module pla_array_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_line = '0;
  logic [7:0] cfg_and = '0;
  logic [2:0] cfg_or = '0;
  logic [3:0] din = '0;
  logic [2:0] dout_p;
  logic [2:0] dout_f;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  logic [7:0] m_and [8];
  logic [2:0] m_or  [8];

  always #5 clk = ~clk;

  pla_array #(.FIXED_OR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .cfg_and(cfg_and), .cfg_or(cfg_or), .din(din), .dout(dout_p)
  );

  pla_array #(.FIXED_OR(1'b1)) uut_fix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .cfg_and(cfg_and), .cfg_or(cfg_or), .din(din), .dout(dout_f)
  );

  function automatic logic [2:0] model(input bit fixed, input logic [3:0] x);
    logic [2:0] r;
    r = '0;
    for (int k = 0; k < 8; k++) begin
      logic t;
      t = 1'b1;
      for (int i = 0; i < 4; i++) begin
        case (m_and[k][2*i +: 2])
          2'b01: t = t & x[i];
          2'b10: t = t & ~x[i];
          2'b11: t = 1'b0;
          default: ;
        endcase
      end
      if (fixed) begin
        if (k < 6) r[k/2] = r[k/2] | t;
      end else begin
        r = r | (m_or[k] & {3{t}});
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(input int line, input logic [7:0] a, input logic [2:0] o);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_line = 3'(line); cfg_and = a; cfg_or = o;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_and[line] = a;
    m_or[line]  = o;
  endtask

  task automatic apply(input logic [3:0] v);
    @(posedge clk); #1;
    din = v;
    @(negedge clk);
  endtask

  // Reference comparison every clock (R8: combinational outputs, writes at the edge)
  always @(negedge clk) begin
    if (live && !done) begin
      check("R8 model prog", dout_p, model(1'b0, din));
      check("R8 model fixed", dout_f, model(1'b1, din));
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8 got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      m_and[k] = 8'hFF;
      m_or[k]  = 3'b000;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 reset prog", dout_p, 3'b000);
    check("R1 reset fixed", dout_f, 3'b000);
    live = 1'b1;

    // R3 empty term
    wr(0, 8'h00, 3'b001);
    apply(4'h0);
    check("R3 empty term prog", dout_p, 3'b001);
    check("R3 empty term fixed", dout_f, 3'b001);
    apply(4'hF);
    check("R3 empty term prog", dout_p, 3'b001);

    // R2 true literal
    wr(0, 8'h01, 3'b001);
    apply(4'h0);
    check("R2 true lit low", dout_p, 3'b000);
    apply(4'h1);
    check("R2 true lit high", dout_p, 3'b001);
    check("R2 true lit fixed", dout_f, 3'b001);
    // R2 complement literal
    wr(0, 8'h02, 3'b001);
    apply(4'h0);
    check("R2 comp lit low", dout_p, 3'b001);
    apply(4'h1);
    check("R2 comp lit high", dout_p, 3'b000);
    // R2 kill code
    wr(0, 8'h31, 3'b001);
    apply(4'h1);
    check("R2 kill", dout_p, 3'b000);
    apply(4'h5);
    check("R2 kill", dout_p, 3'b000);
    check("R2 kill fixed", dout_f, 3'b000);

    // R6 XOR cover
    wr(0, 8'h06, 3'b001);
    wr(1, 8'h09, 3'b001);
    for (int a = 0; a < 4; a++) begin
      apply(4'(a));
      check("R6 xor prog", dout_p, {2'b00, 1'(a[0] ^ a[1])});
      check("R6 xor fixed", dout_f, {2'b00, 1'(a[0] ^ a[1])});
    end

    // R5 shared term, R7 fixed ignores OR data
    wr(2, 8'h10, 3'b110);
    apply(4'h4);
    check("R5 shared prog", dout_p, 3'b110);
    check("R7 fixed group", dout_f, 3'b010);
    apply(4'h0);
    check("R5 shared off", dout_p, 3'b000);

    // R4 no selection, R7 fixed unchanged
    wr(2, 8'h10, 3'b000);
    apply(4'h4);
    check("R4 empty output", dout_p, 3'b000);
    check("R7 or data ignored", dout_f, 3'b010);

    // R9 line outside groups
    wr(6, 8'h00, 3'b111);
    apply(4'h0);
    check("R4 sum all", dout_p, 3'b111);
    check("R9 spare line", dout_f, 3'b000);

    // R7 last group
    wr(5, 8'h00, 3'b000);
    apply(4'h0);
    check("R7 group two", dout_f, 3'b100);
    check("R7 prog unchanged", dout_p, 3'b111);

    // R8 no write without enable
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_line = 3'd3; cfg_and = 8'h00; cfg_or = 3'b111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 write disabled", dout_f, 3'b100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule